// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block is the external bus engine of a small 8-bit processor with a 16-bit address space. The low address byte and the data byte share one bidirectional bus. The processor core hands it one request at a time. A request carries a cycle kind (opcode fetch, memory read, memory write, I/O read or I/O write), an address and, for writes, a data byte. The sequencer then steps through T-states. In each T-state it drives the dedicated upper-address bus, the shared address/data bus with its output enable, the address-latch strobe, the active-low read and write strobes, the memory/I-O select and two status bits.

The sequencer stretches the cycle with wait states while the ready input is low. It captures read data from the shared bus and returns it to the core with a one-clock completion pulse. Between cycles it can hand the buses to another master. The other master asserts a hold request, and the block answers with a hold acknowledge and floats its address and data drivers.

Top module: `bus_cycle_seq`

## Requirements
- R1: The cycle kind codes are 0 = opcode fetch, 1 = memory read, 2 = memory write, 3 = I/O read and 4 = I/O write. A request is taken on a clock edge where `req_valid` is high, `req_ready` is high and `hold` is low. T1 starts on the following cycle. Without waits, a fetch occupies 4 T-states and every other kind occupies 3. `req_ready` is high exactly while the block is idle.
- R2: `ale` is high only in T1. In T1, `ad_oe` is high and `ad_out` carries address bits 7:0. `addr_hi` carries address bits 15:8 for the whole cycle and keeps that value while idle.
- R3: In a fetch or read, `rd_n` is low in T2, in every wait state and in T3. It is high in T1 and in the fetch's T4. `wr_n` stays high for the whole cycle, and `ad_oe` is low after T1.
- R4: In a write, `wr_n` is low in T2, in every wait state and in T3. From T2 through T3, `ad_oe` is high and `ad_out` carries the write data. `rd_n` stays high.
- R5: During a cycle, `io_m` is 1 for I/O kinds and 0 for memory kinds. The status pair {`s1`,`s0`} is 2'b11 for a fetch, 2'b10 for both read kinds and 2'b01 for both write kinds. Outside a cycle, `io_m`, `s1` and `s0` are 0.
- R6: `ready` is sampled at the end of T2 and at the end of each wait state. While it is low, one more wait state is added, with the same strobe, status and bus values as T2.
- R7: A hold request is honoured only at a cycle boundary. That means while idle, or when `hold` is seen high at the end of the last T-state. On the next cycle `hlda` is high, `addr_oe` and `ad_oe` are low and both strobes are high. This lasts until `hold` is seen low, and `hlda` drops on the following cycle. A hold raised mid-cycle never shortens that cycle.
- R8: On a fetch or read, `rdata` takes the value on `ad_in` at the end of T3. `done` is high for exactly the one cycle after T3 for every kind. Writes leave `rdata` unchanged.
- R9: After reset the outputs are as follows. `ale`, `done`, `hlda`, `ad_oe`, `io_m`, `s1` and `s0` are 0. `rd_n`, `wr_n`, `addr_oe` and `req_ready` are 1. `rdata` and `addr_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests a machine cycle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| addr_hi | output | 8 | Upper address bus |
| ad_out | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input value |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| addr_oe | output | 1 | Upper address and strobe drive enable |
| ready | input | 1 | Slave ready, low inserts waits |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Hold acknowledge |

## Verification
The bench targets the following corner cases:
- **Fetch T4.** A design that kept the read strobe low in T4, or captured data there, would show `rd_n` low one cycle too long, or a zero in `rdata`.
- **Wait states.** Waits on both reads and writes must stretch the strobe by exactly the wait count. An off-by-one in the ready sampling changes the measured strobe length.
- **Hold raised inside a cycle.** A design that honoured hold mid-cycle would raise `hlda` before `done`.
- **Hold and a request arriving together.** The bench expects the hold to win.
- **Write after read.** The bench expects a write to leave `rdata` untouched.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam logic [2:0] CYC_FETCH = 3'd0;
  localparam logic [2:0] CYC_MRD   = 3'd1;
  localparam logic [2:0] CYC_MWR   = 3'd2;
  localparam logic [2:0] CYC_IORD  = 3'd3;
  localparam logic [2:0] CYC_IOWR  = 3'd4;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4,
    TS_T4   = 3'd5,
    TS_HOLD = 3'd6
  } tstate_e;

  typedef struct packed {
    logic ale;
    logic rd_n;
    logic wr_n;
    logic io_m;
    logic s1;
    logic s0;
    logic ad_oe;
    logic addr_oe;
    logic hlda;
    logic req_ready;
  } pins_t;

  function automatic logic kind_is_write(input logic [2:0] k);
    return (k == CYC_MWR) || (k == CYC_IOWR);
  endfunction

  function automatic logic kind_is_io(input logic [2:0] k);
    return (k == CYC_IORD) || (k == CYC_IOWR);
  endfunction

  function automatic logic kind_is_fetch(input logic [2:0] k);
    return k == CYC_FETCH;
  endfunction

  function automatic logic in_strobe_phase(input tstate_e s);
    return (s == TS_T2) || (s == TS_TW) || (s == TS_T3);
  endfunction

endpackage

// File: rtl/bus_tstate_fsm.sv
module bus_tstate_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] kind_q,
  input  logic       ready,
  input  logic       hold,
  output tstate_e    state,
  output tstate_e    state_nxt,
  output logic       accept
);

  always_comb begin
    state_nxt = state;
    accept    = 1'b0;
    case (state)
      TS_IDLE: begin
        if (hold) begin
          state_nxt = TS_HOLD;
        end else if (req_valid) begin
          accept    = 1'b1;
          state_nxt = TS_T1;
        end
      end
      TS_T1:       state_nxt = TS_T2;
      TS_T2, TS_TW: state_nxt = ready ? TS_T3 : TS_TW;
      TS_T3: begin
        if (kind_is_fetch(kind_q)) state_nxt = TS_T4;
        else                       state_nxt = hold ? TS_HOLD : TS_IDLE;
      end
      TS_T4:   state_nxt = hold ? TS_HOLD : TS_IDLE;
      TS_HOLD: state_nxt = hold ? TS_HOLD : TS_IDLE;
      default: state_nxt = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= TS_IDLE;
    else     state <= state_nxt;
  end

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (rst)
    ((state == TS_T2 || state == TS_TW) && !ready) |=> (state == TS_TW)); // R6

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (state == TS_HOLD && hold) |=> (state == TS_HOLD)); // R7

  AST_T1_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (state == TS_T1) |-> $past(state == TS_IDLE)); // R1

endmodule

// File: rtl/bus_req_latch.sv
module bus_req_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [2:0]        kind_q,
  output logic [2:0]        kind_nxt,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic [DATA_W-1:0] wdata_nxt
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign kind_nxt  = accept ? req_kind  : kind_q;
  assign addr_nxt  = accept ? req_addr  : addr_q;
  assign wdata_nxt = accept ? req_wdata : wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      kind_q  <= kind_nxt;
      addr_q  <= addr_nxt;
      wdata_q <= wdata_nxt;
    end
  end

endmodule

// File: rtl/bus_pin_drive.sv
module bus_pin_drive
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  tstate_e           state_nxt,
  input  logic [2:0]        kind_nxt,
  input  logic [ADDR_W-1:0] addr_nxt,
  input  logic [DATA_W-1:0] wdata_nxt,
  output pins_t             pins,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out
);

  pins_t             p_nxt;
  logic [DATA_W-1:0] ad_nxt;
  logic              wr_kind;
  logic              in_cycle;

  assign wr_kind  = kind_is_write(kind_nxt);
  assign in_cycle = (state_nxt == TS_T1) || in_strobe_phase(state_nxt) ||
                    (state_nxt == TS_T4);

  always_comb begin
    p_nxt           = '0;
    p_nxt.rd_n      = 1'b1;
    p_nxt.wr_n      = 1'b1;
    p_nxt.addr_oe   = 1'b1;
    p_nxt.req_ready = (state_nxt == TS_IDLE);
    ad_nxt          = wdata_nxt;
    if (in_cycle) begin
      p_nxt.io_m = kind_is_io(kind_nxt);
      if (kind_is_fetch(kind_nxt)) begin
        p_nxt.s1 = 1'b1;
        p_nxt.s0 = 1'b1;
      end else if (wr_kind) begin
        p_nxt.s1 = 1'b0;
        p_nxt.s0 = 1'b1;
      end else begin
        p_nxt.s1 = 1'b1;
        p_nxt.s0 = 1'b0;
      end
    end
    if (state_nxt == TS_T1) begin
      p_nxt.ale   = 1'b1;
      p_nxt.ad_oe = 1'b1;
      ad_nxt      = addr_nxt[DATA_W-1:0];
    end
    if (in_strobe_phase(state_nxt)) begin
      if (wr_kind) begin
        p_nxt.wr_n  = 1'b0;
        p_nxt.ad_oe = 1'b1;
      end else begin
        p_nxt.rd_n  = 1'b0;
      end
    end
    if (state_nxt == TS_HOLD) begin
      p_nxt.hlda    = 1'b1;
      p_nxt.addr_oe = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins           <= '0;
      pins.rd_n      <= 1'b1;
      pins.wr_n      <= 1'b1;
      pins.addr_oe   <= 1'b1;
      pins.req_ready <= 1'b1;
      addr_hi        <= '0;
      ad_out         <= '0;
    end else begin
      pins    <= p_nxt;
      addr_hi <= addr_nxt[ADDR_W-1:DATA_W];
      ad_out  <= ad_nxt;
    end
  end

  AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    pins.ale |=> !pins.ale); // R2

  AST_ALE_BUS_ADDR: assert property (@(posedge clk) disable iff (rst)
    pins.ale |-> (pins.ad_oe && pins.rd_n && pins.wr_n)); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!pins.rd_n && !pins.wr_n)); // R3

  AST_HLDA_FLOAT: assert property (@(posedge clk) disable iff (rst)
    pins.hlda |-> (!pins.addr_oe && !pins.ad_oe && pins.rd_n && pins.wr_n)); // R7

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    !pins.rd_n |-> !pins.ad_oe); // R3

endmodule

// File: rtl/bus_rdata_capture.sv
module bus_rdata_capture
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tstate_e           state,
  input  logic [2:0]        kind_q,
  input  logic [DATA_W-1:0] ad_in,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  logic last_strobe;
  assign last_strobe = (state == TS_T3);

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= last_strobe;
      if (last_strobe && !kind_is_write(kind_q)) rdata <= ad_in;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic              addr_oe,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda
);

  tstate_e           state, state_nxt;
  logic              accept;
  logic [2:0]        kind_q, kind_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [DATA_W-1:0] wdata_nxt;
  pins_t             pins;

  bus_tstate_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .kind_q    (kind_q),
    .ready     (ready),
    .hold      (hold),
    .state     (state),
    .state_nxt (state_nxt),
    .accept    (accept)
  );

  bus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .kind_q    (kind_q),
    .kind_nxt  (kind_nxt),
    .addr_nxt  (addr_nxt),
    .wdata_nxt (wdata_nxt)
  );

  bus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .state_nxt (state_nxt),
    .kind_nxt  (kind_nxt),
    .addr_nxt  (addr_nxt),
    .wdata_nxt (wdata_nxt),
    .pins      (pins),
    .addr_hi   (addr_hi),
    .ad_out    (ad_out)
  );

  bus_rdata_capture #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .state (state),
    .kind_q(kind_q),
    .ad_in (ad_in),
    .done  (done),
    .rdata (rdata)
  );

  assign ale       = pins.ale;
  assign rd_n      = pins.rd_n;
  assign wr_n      = pins.wr_n;
  assign io_m      = pins.io_m;
  assign s1        = pins.s1;
  assign s0        = pins.s0;
  assign ad_oe     = pins.ad_oe;
  assign addr_oe   = pins.addr_oe;
  assign hlda      = pins.hlda;
  assign req_ready = pins.req_ready;

  AST_DONE_NOT_IN_HOLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (hlda && !$past(hlda)) |-> !ale); // R7

endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        req_ready, done, ad_oe, ale, rd_n, wr_n, io_m, s1, s0, addr_oe, hlda;
  logic [7:0]  rdata, addr_hi, ad_out, ad_in;
  logic        ready = 1'b1;
  logic        hold = 1'b0;

  int total = 0;
  int bad = 0;
  int waits_left = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .addr_hi(addr_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .io_m(io_m), .s1(s1), .s0(s0), .addr_oe(addr_oe), .ready(ready),
    .hold(hold), .hlda(hlda)
  );

  // behavioural reference: phase 0 idle, 1 T1, 2 T2/wait, 3 T3, 4 T4, 5 hold
  int          m_ph = 0;
  logic [2:0]  m_kind = 3'd0;
  logic [15:0] m_addr = 16'h0;
  logic [7:0]  m_wdata = 8'h0;
  logic        m_done = 1'b0;
  logic [7:0]  m_rdata = 8'h0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic bit is_wr(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction
  function automatic bit is_io(input logic [2:0] k);
    return (k == 3'd3) || (k == 3'd4);
  endfunction

  assign ad_in = rd_n ? 8'h00 : pat(m_addr);

  always @(posedge clk) begin
    if (rst) begin
      m_ph <= 0; m_kind <= 3'd0; m_addr <= 16'h0; m_wdata <= 8'h0;
      m_done <= 1'b0; m_rdata <= 8'h0;
    end else begin
      m_done <= 1'b0;
      case (m_ph)
        0: if (hold) m_ph <= 5;
           else if (req_valid) begin
             m_ph <= 1; m_kind <= req_kind; m_addr <= req_addr; m_wdata <= req_wdata;
           end
        1: m_ph <= 2;
        2: if (ready) m_ph <= 3;
        3: begin
             m_done <= 1'b1;
             if (!is_wr(m_kind)) m_rdata <= pat(m_addr);
             if (m_kind == 3'd0) m_ph <= 4;
             else m_ph <= hold ? 5 : 0;
           end
        4: m_ph <= hold ? 5 : 0;
        default: if (!hold) m_ph <= 0;
      endcase
    end
  end

  always @(posedge clk) begin
    #1;
    if (m_ph == 2 && waits_left > 0) begin
      ready = 1'b0;
      waits_left--;
    end else begin
      ready = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit cyc, strobe, wr, e_ale, e_oe, e_rd, e_wr, e_io, e_s1, e_s0;
      cyc    = (m_ph >= 1 && m_ph <= 4);
      strobe = (m_ph == 2 || m_ph == 3);
      wr     = is_wr(m_kind);
      e_ale  = (m_ph == 1);
      e_oe   = e_ale || (wr && strobe);
      e_rd   = !(strobe && !wr);
      e_wr   = !(strobe && wr);
      e_io   = cyc && is_io(m_kind);
      e_s1   = cyc && !wr;
      e_s0   = cyc && (wr || m_kind == 3'd0);
      chk(req_ready == (m_ph == 0), "R1 req_ready", req_ready, m_ph == 0);
      chk(ale == e_ale, "R2 ale", ale, e_ale);
      chk(ad_oe == e_oe, "R2/R4 ad_oe", ad_oe, e_oe);
      if (e_oe)
        chk(ad_out == (e_ale ? m_addr[7:0] : m_wdata), "R2/R4 ad_out", ad_out,
            e_ale ? m_addr[7:0] : m_wdata);
      if (m_ph != 5) chk(addr_hi == m_addr[15:8], "R2 addr_hi", addr_hi, m_addr[15:8]);
      chk(rd_n == e_rd, "R3 rd_n", rd_n, e_rd);
      chk(wr_n == e_wr, "R4 wr_n", wr_n, e_wr);
      chk({io_m, s1, s0} == {e_io, e_s1, e_s0}, "R5 io_m/s1/s0",
          {io_m, s1, s0}, {e_io, e_s1, e_s0});
      chk(hlda == (m_ph == 5) && addr_oe == (m_ph != 5), "R7 hlda/addr_oe",
          {hlda, addr_oe}, {m_ph == 5, m_ph != 5});
      chk(done == m_done, "R8 done", done, m_done);
      chk(rdata == m_rdata, "R8 rdata", rdata, m_rdata);
    end
  end

  // issue one cycle, measure T-states and strobe-low clocks
  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input int waits);
    int n, strobe_n;
    bit saw_done;
    logic [7:0] rd_before;
    rd_before  = m_rdata;
    waits_left = waits;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    do begin
      @(posedge clk); #1;
    end while (m_ph != 1);
    req_valid = 1'b0;
    n = 0; strobe_n = 0; saw_done = 1'b0;
    forever begin
      @(negedge clk);
      if (done) saw_done = 1'b1;
      if (!rd_n || !wr_n) strobe_n++;
      if (req_ready || hlda) break;
      n++;
    end
    chk(n == ((k == 3'd0) ? 4 : 3) + waits, "R1 cycle length", n,
        ((k == 3'd0) ? 4 : 3) + waits);
    chk(strobe_n == 2 + waits, "R6 strobe low clocks", strobe_n, 2 + waits);
    chk(saw_done, "R8 done seen", saw_done, 1);
    if (is_wr(k)) chk(rdata == rd_before, "R8 write keeps rdata", rdata, rd_before);
    else          chk(rdata == pat(a), "R8 read data", rdata, pat(a));
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(ale == 0 && done == 0 && hlda == 0 && ad_oe == 0 && {io_m, s1, s0} == 0,
        "R9 reset lows", {ale, done, hlda, ad_oe, io_m, s1, s0}, 0);
    chk(rd_n && wr_n && addr_oe && req_ready, "R9 reset highs",
        {rd_n, wr_n, addr_oe, req_ready}, 4'hF);
    chk(rdata == 0 && addr_hi == 0, "R9 reset data", {rdata, addr_hi}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #1;

    run_cycle(3'd0, 16'h2000, 8'h00, 0);   // fetch
    run_cycle(3'd1, 16'h2001, 8'h00, 0);   // memory read
    run_cycle(3'd2, 16'h31C4, 8'h5E, 0);   // memory write
    run_cycle(3'd3, 16'h0042, 8'h00, 0);   // io read
    run_cycle(3'd4, 16'h0081, 8'h99, 0);   // io write
    run_cycle(3'd1, 16'hBEEF, 8'h00, 3);   // read with waits
    run_cycle(3'd4, 16'h1234, 8'h3C, 2);   // write with waits
    run_cycle(3'd0, 16'hFFFF, 8'h00, 1);   // fetch with wait

    // hold while idle
    hold = 1'b1;
    @(negedge clk);
    chk(hlda == 0, "R7 hlda not before edge", hlda, 0);
    @(negedge clk);
    chk(hlda == 1 && addr_oe == 0 && ad_oe == 0, "R7 hold granted",
        {hlda, addr_oe, ad_oe}, 3'b100);
    repeat (3) @(posedge clk);
    #1; hold = 1'b0;
    @(negedge clk);
    chk(hlda == 1, "R7 hlda until hold seen low", hlda, 1);
    @(negedge clk);
    chk(hlda == 0 && req_ready == 1, "R7 hlda released", {hlda, req_ready}, 2'b01);
    @(posedge clk); #1;

    // hold raised mid-cycle: cycle completes first
    fork
      run_cycle(3'd1, 16'h4455, 8'h00, 2);
      begin
        wait (m_ph == 1);
        @(posedge clk); #2;
        hold = 1'b1;
      end
    join
    chk(hlda == 1, "R7 hold after boundary", hlda, 1);
    repeat (2) @(posedge clk);
    #1; hold = 1'b0;
    repeat (2) @(posedge clk);
    #1;

    // hold and request together: hold wins
    hold = 1'b1; req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h7788; req_wdata = 8'hC3;
    @(negedge clk);
    @(negedge clk);
    chk(hlda == 1 && ale == 0, "R7 hold beats request", {hlda, ale}, 2'b10);
    @(posedge clk); #1;
    hold = 1'b0; req_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    run_cycle(3'd2, 16'h7788, 8'hC3, 0);

    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule